// File: doc/BRIEF.md
# Switchable-Sign Registered Adder

This block is one registered adder node for a pipelined constant-multiplier graph that must switch between several coefficients at run time. Each operand carries its own negate flag, so the same adder can compute a+b in one configuration, a−b in another and −a+b in a third, without a second adder.

Negation is done inside one carry chain. Each operand is inverted bit by bit according to its flag, and the missing +1 of each negation is added back as a carry-in derived from the flags. A parameter selects the two-input form or the three-input form. In the three-input form the operands first pass through a carry-save stage, and the correction of up to three units rides on the carry-propagate adder that follows. The result is one pipeline stage deep, and its width is chosen so that no legal case can overflow.

Top module: `sw_addsub`

## Requirements
- R1: While `rst_n` is low, `sum` and `err` are 0.
- R2: Results appear exactly one clock after the inputs are sampled, and `sum` holds its value between rising clock edges.
- R3: With `THREE`=0, operands are W-bit signed two's complement, and a flag value of 1 means that operand is subtracted. For flag pairs (neg_a,neg_b) = 00, 01 and 10, `sum` is the exact W+1-bit signed value of (±op_a)+(±op_b).
- R4: With `THREE`=0, `op_c` and `neg_c` have no effect on `sum` or `err`.
- R5: With `THREE`=0, setting `neg_a` and `neg_b` at the same time is an unsupported case. One clock later `err` is 1 and `sum` holds no unknown bits. In every legal case `err` is 0.
- R6: With `THREE`=1, all eight flag combinations give the exact W+2-bit signed value of (±op_a)+(±op_b)+(±op_c). This covers a+b+c, a−b+c, a+b−c and a−b−c.
- R7: With `THREE`=1, `err` stays 0.
- R8: Operands at the most negative and most positive W-bit values give exact results, with no wrap-around, in every legal flag combination.
- R9: With `THREE`=1, setting `op_c` to 0 makes the result equal to the two-operand result (±op_a)+(±op_b), whatever the value of `neg_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| op_c | input | W | Third signed operand, used only when THREE=1 |
| neg_a | input | 1 | 1 subtracts op_a |
| neg_b | input | 1 | 1 subtracts op_b |
| neg_c | input | 1 | 1 subtracts op_c, used only when THREE=1 |
| sum | output | W+1 (THREE=0) or W+2 (THREE=1) | Registered signed result |
| err | output | 1 | Registered flag for the unsupported two-input flag pair |

## Verification
The bench builds two instances side by side with W=8, one with THREE=0 and one with THREE=1, and drives both from the same inputs. An 8-bit width keeps the operand extremes −128 and 127 cheap to reach. It lets every pairing of extreme operands be run against every flag combination, which exercises the full headroom of the W+1 and W+2 result widths. Running the two forms together also shows the third operand being ignored in one instance while the other adds it.

// File: rtl/sw_addsub.sv
module sw_addsub #(
  parameter int W     = 16,
  parameter bit THREE = 1'b0,
  localparam int OW   = THREE ? W + 2 : W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  op_c,
  input  logic          neg_a,
  input  logic          neg_b,
  input  logic          neg_c,
  output logic [OW-1:0] sum,
  output logic          err
);

  logic [OW-1:0] xa, xb, xc, nxt;
  logic          bad;

  // sign-extend, then invert when the operand is to be subtracted
  assign xa = OW'($signed(op_a)) ^ {OW{neg_a}};
  assign xb = OW'($signed(op_b)) ^ {OW{neg_b}};
  // the third port is fed zero when it is not in use
  assign xc = THREE ? (OW'($signed(op_c)) ^ {OW{neg_c}}) : '0;

  generate
    if (THREE) begin : g_three
      logic [OW-1:0] ps, maj, pc;
      logic [1:0]    corr;
      assign ps   = xa ^ xb ^ xc;
      assign maj  = (xa & xb) | (xa & xc) | (xb & xc);
      assign pc   = maj << 1;
      assign corr = 2'(neg_a) + 2'(neg_b) + 2'(neg_c);
      assign nxt  = ps + pc + OW'(corr);
      assign bad  = 1'b0;
    end else begin : g_two
      assign nxt = xa + xb + xc + OW'(neg_a | neg_b);
      assign bad = neg_a & neg_b;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      err <= 1'b0;
    end else begin
      sum <= nxt;
      err <= bad;
    end
  end

endmodule

// File: rtl/sw_addsub_chk.sv
module sw_addsub_chk #(
  parameter int W     = 16,
  parameter bit THREE = 1'b0,
  localparam int OW   = THREE ? W + 2 : W + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [W-1:0]  op_c,
  input logic          neg_a,
  input logic          neg_b,
  input logic          neg_c,
  input logic [OW-1:0] sum,
  input logic          err
);

  logic signed [OW-1:0] ea, eb, ec, want;
  assign ea   = OW'($signed(op_a));
  assign eb   = OW'($signed(op_b));
  assign ec   = OW'($signed(op_c));
  assign want = (neg_a ? -ea : ea) + (neg_b ? -eb : eb)
              + (THREE ? (neg_c ? -ec : ec) : '0);

  a_r3_two_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (!THREE && !(neg_a && neg_b)) |=> (sum == $past(want)));

  a_r6_three_sum: assert property (@(posedge clk) disable iff (!rst_n)
    THREE |=> (sum == $past(want)));

  a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err == $past(!THREE && neg_a && neg_b)));

  a_r5_no_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({sum, err}));

  a_r7_three_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    THREE |-> !err);

endmodule

bind sw_addsub sw_addsub_chk #(.W(W), .THREE(THREE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
  .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c), .sum(sum), .err(err)
);

// File: tb/test_sw_addsub.sv
module test_sw_addsub;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic neg_a = 1'b0, neg_b = 1'b0, neg_c = 1'b0;
  logic [W:0]   sum2;
  logic [W+1:0] sum3;
  logic err2, err3;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  sw_addsub #(.W(W), .THREE(1'b0)) i_sw_addsub (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c), .sum(sum2), .err(err2));

  sw_addsub #(.W(W), .THREE(1'b1)) i_sw_addsub3 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c), .sum(sum3), .err(err3));

  function automatic int model(int a, int b, int c, bit na, bit nb, bit nc, bit use_c);
    return (na ? -a : a) + (nb ? -b : b) + (use_c ? (nc ? -c : c) : 0);
  endfunction

  function automatic int s8(int v);
    return int'($signed(8'(v)));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(int a, int b, int c, bit na, bit nb, bit nc);
    @(negedge clk);
    op_a = 8'(a); op_b = 8'(b); op_c = 8'(c);
    neg_a = na; neg_b = nb; neg_c = nc;
    @(posedge clk);
    #1;
  endtask

  function automatic int got2();
    return int'($signed(sum2));
  endfunction

  function automatic int got3();
    return int'($signed(sum3));
  endfunction

  task automatic t_reset();
    op_a = 8'h55; op_b = 8'h33; op_c = 8'h11; neg_b = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 two sum", got2(), 0);
    chk("R1 two err", int'(err2), 0);
    chk("R1 three sum", got3(), 0);
    chk("R1 three err", int'(err3), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_two_sweep();
    for (int i = 0; i < 40; i++) begin
      for (int f = 0; f < 3; f++) begin
        int a = s8($urandom), b = s8($urandom);
        bit na = (f == 1), nb = (f == 2);
        put(a, b, 0, na, nb, 1'b0);
        chk("R3 two sum", got2(), model(a, b, 0, na, nb, 0, 0));
        chk("R5 legal err", int'(err2), 0);
      end
    end
  endtask

  task automatic t_extremes();
    int v[4] = '{-128, 127, 0, -1};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          for (int f = 0; f < 8; f++) begin
            bit na = f[0], nb = f[1], nc = f[2];
            put(v[i], v[j], v[k], na, nb, nc);
            chk("R8 three extreme", got3(), model(v[i], v[j], v[k], na, nb, nc, 1));
            if (!(na && nb))
              chk("R8 two extreme", got2(), model(v[i], v[j], 0, na, nb, 0, 0));
          end
  endtask

  task automatic t_two_ignore_c();
    for (int i = 0; i < 30; i++) begin
      int a = s8($urandom), b = s8($urandom), c = s8($urandom);
      bit na = (i % 3 == 1), nb = (i % 3 == 2);
      put(a, b, c, na, nb, i[0]);
      chk("R4 c ignored", got2(), model(a, b, 0, na, nb, 0, 0));
      chk("R4 c no err", int'(err2), 0);
    end
  endtask

  task automatic t_two_bad();
    put(100, -50, 0, 1'b1, 1'b1, 1'b0);
    chk("R5 err set", int'(err2), 1);
    chk("R5 no unknown", int'($isunknown(sum2)), 0);
    put(100, -50, 0, 1'b1, 1'b0, 1'b0);
    chk("R5 err clears", int'(err2), 0);
    chk("R3 after bad", got2(), -150);
  endtask

  task automatic t_three_sweep();
    for (int i = 0; i < 30; i++)
      for (int f = 0; f < 8; f++) begin
        int a = s8($urandom), b = s8($urandom), c = s8($urandom);
        put(a, b, c, f[0], f[1], f[2]);
        chk("R6 three sum", got3(), model(a, b, c, f[0], f[1], f[2], 1));
        chk("R7 three err", int'(err3), 0);
      end
  endtask

  task automatic t_three_zero_c();
    for (int i = 0; i < 24; i++) begin
      int a = s8($urandom), b = s8($urandom);
      bit na = i[0], nb = i[1], nc = i[2];
      put(a, b, 0, na, nb, nc);
      chk("R9 zero c", got3(), model(a, b, 0, na, nb, 0, 0));
    end
  endtask

  task automatic t_latency();
    put(10, 20, 0, 1'b0, 1'b1, 1'b0);
    chk("R2 first", got2(), -10);
    @(negedge clk);
    op_a = 8'(50); op_b = 8'(7); neg_b = 1'b0;
    #1;
    chk("R2 held before edge", got2(), -10);
    @(posedge clk);
    #1;
    chk("R2 after edge", got2(), 57);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_two_sweep();
    t_two_ignore_c();
    t_two_bad();
    t_three_sweep();
    t_three_zero_c();
    t_extremes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule